// File: doc/BRIEF.md
# Programmable Tick Source Divider Gate

This block derives one clock-enable stream from a set of single-cycle tick inputs. All ticks belong to one reference clock domain. A selector picks one of four source tick lines. An override bit can force an alternate tick line instead, and the override wins over the selector. Two cascaded counters then divide the chosen ticks, each by its programmed divisor plus one. The block produces two outputs: a one-cycle enable pulse for every completed output period, and a level signal that is high for the first half of each period.

Configuration lives in one 16-bit control word. It is written through a single-cycle write strobe and is always visible on a readback port. Three instance parameters remove the second divisor, the override bit and the spare bit 14. A removed field reads as zero, ignores writes and behaves as zero.

A new source or divisor setting is not applied at once. It is copied into the active configuration only at a period start, where no tick of the new period has been counted yet. An output period is therefore never cut short.

Top module: `clk_tick_divgate`

## Requirements
- R1: While reset is asserted, the control readback is 0x0000 and both `tick_en_o` and `div_clk_o` are 0.
- R2: On an instance with every feature present, a write stores bits 15, 14, 13:12, 11 and 7:0. Bits 10:8 always read as zero. The stored value appears on `ctrl_o` in the cycle after the write.
- R3: While bit 15 (disable) is set, `tick_en_o` and `div_clk_o` stay 0 from the next cycle onward. Both counters and the period position return to zero, so the first pulse after re-enabling needs a full period of ticks.
- R4: With bit 11 clear, field 13:12 picks `src_tick_i[sel]`, where sel is 0 to 3.
- R5: With bit 11 set, `alt_tick_i` is counted and field 13:12 is ignored.
- R6: With N = (bits 3:0 + 1) × (bits 7:4 + 1), `tick_en_o` pulses for one cycle, one cycle after every N-th selected tick.
- R7: With both divisor fields zero, `tick_en_o` is the selected tick delayed by one cycle.
- R8: After a selected tick, or while no tick arrives, `div_clk_o` is 1 exactly when the count of ticks taken in the current period is below ceil(N/2). It is 1 in the same cycle as each pulse.
- R9: A change to the source, override or divisor fields takes effect only at a period start: after the tick that ends a period, or in a cycle with no tick while the period position is zero.
- R10: On an instance without the second divisor, the override and bit 14, those bits read zero, ignore writes and act as zero. The writable mask is then 0xB00F.
- R11: Bit 14 is stored and read back but has no effect on the pulse cadence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 4 | Source tick lines, selected by bits 13:12 |
| alt_tick_i | input | 1 | Override tick line, used when bit 11 is set |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write value |
| ctrl_o | output | 16 | Control word readback |
| tick_en_o | output | 1 | One-cycle enable pulse per output period |
| div_clk_o | output | 1 | Divided clock level, high for the first half of each period |

## Verification
The bench writes new divisors in the middle of a period. A design that applied them at once would emit a short period or skip a pulse. It compares an odd period of 5 with a cascaded period of 6. Getting the ceiling wrong makes the level run one tick long or short, and getting the cascade wrong (sum instead of product) changes the pulse cadence. It also drives the override and the selector with tick patterns of different density, toggles the disable bit mid-count, and writes all-ones to a stripped-down instance. A design that leaked a removed field would read back nonzero bits or count from the wrong line.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    localparam int DIV_W   = 4;
    localparam int SEL_W   = 2;
    localparam int NSRC    = 1 << SEL_W;
    localparam int CTRL_W  = 16;

    localparam int OFF_BIT  = 15;
    localparam int SPARE_BIT = 14;
    localparam int SEL_LSB  = 12;
    localparam int OVR_BIT  = 11;
    localparam int D2_LSB   = 4;
    localparam int D1_LSB   = 0;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ovr;
        logic [DIV_W-1:0] div2;
        logic [DIV_W-1:0] div1;
    } cfg_t;

    function automatic logic [CTRL_W-1:0] write_mask(bit has_div2, bit has_ovr, bit has_spare);
        logic [CTRL_W-1:0] m;
        m = '0;
        m[OFF_BIT] = 1'b1;
        m[SEL_LSB +: SEL_W] = '1;
        m[D1_LSB +: DIV_W] = '1;
        if (has_div2)  m[D2_LSB +: DIV_W] = '1;
        if (has_ovr)   m[OVR_BIT] = 1'b1;
        if (has_spare) m[SPARE_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ckdiv_ctrl.sv
module ckdiv_ctrl
    import ckdiv_pkg::*;
#(
    parameter bit HAS_DIV2  = 1'b1,
    parameter bit HAS_OVR   = 1'b1,
    parameter bit HAS_SPARE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl,
    output logic              off,
    output cfg_t              cfg
);

    localparam logic [CTRL_W-1:0] MASK = write_mask(HAS_DIV2, HAS_OVR, HAS_SPARE);

    typedef struct packed {
        logic [CTRL_W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wr_data & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl     = st_q.word;
        off      = st_q.word[OFF_BIT];
        cfg.sel  = st_q.word[SEL_LSB +: SEL_W];
        cfg.ovr  = st_q.word[OVR_BIT];
        cfg.div2 = st_q.word[D2_LSB +: DIV_W];
        cfg.div1 = st_q.word[D1_LSB +: DIV_W];
    end

endmodule

// File: rtl/ckdiv_srcsel.sv
module ckdiv_srcsel
    import ckdiv_pkg::*;
#(
    parameter bit HAS_OVR = 1'b1
) (
    input  logic [NSRC-1:0]  src_tick,
    input  logic             ovr_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             ovr_en,
    output logic             tick
);

    generate
        if (HAS_OVR) begin : g_ovr
            always_comb begin
                tick = ovr_en ? ovr_tick : src_tick[sel];
            end
        end else begin : g_no_ovr
            always_comb begin
                tick = src_tick[sel];
            end
        end
    endgenerate

endmodule

// File: rtl/ckdiv_stage.sv
module ckdiv_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = step && (st_q.cnt == limit);
        if (clear || wrap) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/clk_tick_divgate.sv
module clk_tick_divgate
    import ckdiv_pkg::*;
#(
    parameter bit HAS_DIV2  = 1'b1,
    parameter bit HAS_OVR   = 1'b1,
    parameter bit HAS_SPARE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick_i,
    input  logic              alt_tick_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              tick_en_o,
    output logic              div_clk_o
);

    localparam int POS_W = 2 * DIV_W;
    localparam int N_W   = 2 * (DIV_W + 1);

    typedef struct packed {
        cfg_t             act;
        logic [POS_W-1:0] pos;
        logic             en;
        logic             lvl;
    } st_t;

    st_t  st_d, st_q;
    cfg_t reg_cfg;
    logic off;
    logic sel_tick;
    logic step;
    logic wrap1;
    logic wrap2;
    logic [N_W-1:0] period_n;
    logic [N_W-1:0] half_n;

    ckdiv_ctrl #(
        .HAS_DIV2 (HAS_DIV2),
        .HAS_OVR  (HAS_OVR),
        .HAS_SPARE(HAS_SPARE)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_i),
        .wr_data(wr_data_i),
        .ctrl   (ctrl_o),
        .off    (off),
        .cfg    (reg_cfg)
    );

    ckdiv_srcsel #(
        .HAS_OVR(HAS_OVR)
    ) u_srcsel (
        .src_tick(src_tick_i),
        .ovr_tick(alt_tick_i),
        .sel     (st_q.act.sel),
        .ovr_en  (st_q.act.ovr),
        .tick    (sel_tick)
    );

    assign step = sel_tick & ~off;

    ckdiv_stage #(
        .W(DIV_W)
    ) u_stage1 (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(off),
        .step (step),
        .limit(st_q.act.div1),
        .wrap (wrap1)
    );

    generate
        if (HAS_DIV2) begin : g_div2
            ckdiv_stage #(
                .W(DIV_W)
            ) u_stage2 (
                .clk  (clk),
                .rst_n(rst_n),
                .clear(off),
                .step (wrap1),
                .limit(st_q.act.div2),
                .wrap (wrap2)
            );
        end else begin : g_no_div2
            assign wrap2 = wrap1;
        end
    endgenerate

    always_comb begin
        period_n = (N_W'(st_q.act.div1) + 1'b1) * (N_W'(st_q.act.div2) + 1'b1);
        half_n   = (period_n + 1'b1) >> 1;
    end

    always_comb begin
        st_d    = st_q;
        st_d.en = wrap2;
        if (off) begin
            st_d.pos = '0;
            st_d.act = reg_cfg;
        end else if (wrap2) begin
            st_d.pos = '0;
            st_d.act = reg_cfg;
        end else if (step) begin
            st_d.pos = st_q.pos + 1'b1;
        end else if (st_q.pos == '0) begin
            st_d.act = reg_cfg;
        end
        st_d.lvl = ~off && ({{(N_W-POS_W){1'b0}}, st_d.pos} < half_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_en_o = st_q.en;
    assign div_clk_o = st_q.lvl;

endmodule

// File: rtl/ckdiv_checker.sv
module ckdiv_checker
    import ckdiv_pkg::*;
#(
    parameter bit HAS_DIV2  = 1'b1,
    parameter bit HAS_OVR   = 1'b1,
    parameter bit HAS_SPARE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [CTRL_W-1:0] wr_data_i,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic              tick_en_o,
    input logic              div_clk_o,
    input logic              sel_tick
);

    localparam logic [CTRL_W-1:0] MASK = write_mask(HAS_DIV2, HAS_OVR, HAS_SPARE);

    a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (ctrl_o == ($past(wr_data_i) & MASK)));

    a_r10_ro_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o & ~MASK) == '0);

    a_r3_masked_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[OFF_BIT] |=> !tick_en_o);

    a_r3_masked_level: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[OFF_BIT] |=> !div_clk_o);

    a_r6_pulse_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en_o |-> $past(sel_tick));

    a_r8_pulse_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en_o |-> div_clk_o);

endmodule

bind clk_tick_divgate ckdiv_checker #(
    .HAS_DIV2 (HAS_DIV2),
    .HAS_OVR  (HAS_OVR),
    .HAS_SPARE(HAS_SPARE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl_o),
    .tick_en_o(tick_en_o),
    .div_clk_o(div_clk_o),
    .sel_tick (sel_tick)
);

// File: tb/clk_tick_divgate_bench.sv
module clk_tick_divgate_bench;

    typedef struct {
        int    due;
        logic  en;
        logic  lvl;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src = '0;
    logic        alt = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_a, ctrl_b;
    logic        en_a, en_b, lvl_a, lvl_b;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    gk = 0;
    bit    done = 0;
    string cur_tag = "R1";

    exp_t q_a[$];
    exp_t q_b[$];

    logic [15:0] m_mask [2];
    logic [15:0] m_ctrl [2];
    logic [15:0] m_act  [2];
    int          m_pos  [2];

    always #2 clk = ~clk;

    clk_tick_divgate u_clk_tick_divgate (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src), .alt_tick_i(alt),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .ctrl_o(ctrl_a),
        .tick_en_o(en_a), .div_clk_o(lvl_a)
    );

    clk_tick_divgate #(.HAS_DIV2(1'b0), .HAS_OVR(1'b0), .HAS_SPARE(1'b0)) u_clk_tick_divgate_min (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src), .alt_tick_i(alt),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .ctrl_o(ctrl_b),
        .tick_en_o(en_b), .div_clk_o(lvl_b)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk16(string req, logic [15:0] got, logic [15:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    task automatic cmp(string inst, exp_t e, logic en, logic lvl);
        checks++;
        if (en !== e.en || lvl !== e.lvl) begin
            errors++;
            $display("FAIL %s (%s) cycle %0d: en/lvl got %b%b expected %b%b",
                     e.tag, inst, e.due, en, lvl, e.en, e.lvl);
        end
    endtask

    // Scoreboard monitor: compare each expected item once its cycle has come
    always @(negedge clk) begin
        while (q_a.size() > 0 && q_a[0].due <= cyc) cmp("full", q_a.pop_front(), en_a, lvl_a);
        while (q_b.size() > 0 && q_b[0].due <= cyc) cmp("min", q_b.pop_front(), en_b, lvl_b);
    end

    // Behaviour model from the requirements: one flat tick count per period
    task automatic model_step(int i, logic [3:0] s, logic a, logic w, logic [15:0] d, output exp_t e);
        int n, half;
        logic tick;
        n    = (int'(m_act[i][3:0]) + 1) * (int'(m_act[i][7:4]) + 1);
        half = (n + 1) / 2;
        tick = m_act[i][11] ? a : s[m_act[i][13:12]];
        e.en = 1'b0;
        if (m_ctrl[i][15]) begin
            m_pos[i] = 0; m_act[i] = m_ctrl[i]; e.lvl = 1'b0;
        end else if (tick && m_pos[i] + 1 == n) begin
            m_pos[i] = 0; m_act[i] = m_ctrl[i]; e.en = 1'b1; e.lvl = 1'b1;
        end else if (tick) begin
            m_pos[i] = m_pos[i] + 1; e.lvl = (m_pos[i] < half);
        end else begin
            if (m_pos[i] == 0) m_act[i] = m_ctrl[i];
            e.lvl = (m_pos[i] < half);
        end
        if (w) m_ctrl[i] = d & m_mask[i];
        e.due = cyc + 1;
        e.tag = cur_tag;
    endtask

    // Driver: one reference cycle of stimulus, expectations pushed to the queues
    task automatic drive(logic w, logic [15:0] d);
        exp_t ea, eb;
        @(posedge clk); #1;
        src[0] = (gk % 3) != 2;
        src[1] = (gk % 2) == 1;
        src[2] = (gk % 3) == 0;
        src[3] = (gk % 5) < 2;
        alt    = (gk % 4) == 1;
        gk++;
        wr_en = w; wr_data = d;
        model_step(0, src, alt, w, d, ea);
        model_step(1, src, alt, w, d, eb);
        q_a.push_back(ea);
        q_b.push_back(eb);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) drive(1'b0, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            finish_report();
        end
    end

    initial begin
        m_mask[0] = 16'hF8FF;
        m_mask[1] = 16'hB00F;
        for (int i = 0; i < 2; i++) begin
            m_ctrl[i] = '0; m_act[i] = '0; m_pos[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk16("R1", ctrl_a, 16'h0000);
        chk16("R1", ctrl_b, 16'h0000);
        chk16("R1", {14'd0, en_a, lvl_a}, 16'h0000);
        chk16("R1", {14'd0, en_b, lvl_b}, 16'h0000);
        rst_n = 1'b1;

        cur_tag = "R7"; run(20);

        cur_tag = "R4";
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, (16'(s) << 12) | 16'h0001);
            run(24);
        end

        cur_tag = "R6"; drive(1'b1, 16'h0032); run(50);
        drive(1'b1, 16'h00FF); run(800);

        cur_tag = "R8"; drive(1'b1, 16'h0004); run(30);
        drive(1'b1, 16'h0021); run(30);

        cur_tag = "R5"; drive(1'b1, 16'h2801); run(30);

        cur_tag = "R11"; drive(1'b1, 16'h4003); run(30);

        cur_tag = "R3"; drive(1'b1, 16'h8003); run(15);
        drive(1'b1, 16'h0003); run(20);

        cur_tag = "R9"; drive(1'b1, 16'h0007); run(3);
        drive(1'b1, 16'h0000); run(20);
        drive(1'b1, 16'h1007); run(3);
        drive(1'b1, 16'h3001); run(20);

        cur_tag = "R2";
        drive(1'b1, 16'hFFFF); drive(1'b0, 16'h0000);
        chk16("R2", ctrl_a, 16'hF8FF);
        chk16("R10", ctrl_b, 16'hB00F);
        drive(1'b1, 16'h1234); drive(1'b0, 16'h0000);
        chk16("R2", ctrl_a, 16'h1034);
        chk16("R10", ctrl_b, 16'h1004);
        cur_tag = "R10"; run(30);

        run(4);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_report();
    end

endmodule